// File: doc/BRIEF.md
# Subtractive GCD Engine

The block finds the greatest common divisor of two unsigned operands by repeated subtraction. It needs no divider. It keeps two working registers. On each clock edge it does one of three things: it takes the smaller register away from the larger, it exchanges the two registers, or it holds. The run is over when the first register reaches zero, and the second register then holds the answer.

A client drives the two operands with a one-cycle start pulse while the engine is idle. It then waits for the ready flag and reads the result. A start pulse that arrives while a run is in progress is dropped, and the run continues unchanged. The number of cycles a run takes depends on the operands. It is roughly the sum of the quotients of the Euclidean sequence.

Top module: `gcd_sub_engine`

## Requirements
- R1: After reset both working registers are zero, so `busy_o` is 0, `done_o` is 1 and `result_o` is 0.
- R2: A start pulse taken while idle loads `opa_i` into the first register and `opb_i` into the second on that clock edge. On the next cycle `result_o` equals `opb_i`, and `busy_o` is 1 exactly when `opa_i` is nonzero.
- R3: While both registers are nonzero and the first is greater than or equal to the second, the first register becomes its value minus the second, and the second register is unchanged.
- R4: While the first register is nonzero and smaller than the second, the two registers exchange their values in one cycle.
- R5: When the first register is nonzero and the second is zero, the registers are exchanged. The run ends on the next cycle with `result_o` equal to the nonzero operand.
- R6: While the first register is zero and no start is taken, both registers hold their values, so `done_o` stays 1 and `result_o` stays stable.
- R7: `busy_o` is 1 exactly when the first register is nonzero, `done_o` is its complement, and `result_o` always shows the second register.
- R8: A start pulse seen while `busy_o` is 1 has no effect on the registers or on the final result.
- R9: When `done_o` rises after a start, `result_o` equals the greatest common divisor of the operands, with gcd(0, n) = n. For 15 and 6 this is 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Load request, taken only while idle |
| opa_i | input | WIDTH | Operand placed in the first register |
| opb_i | input | WIDTH | Operand placed in the second register |
| busy_o | output | 1 | A computation is in progress |
| done_o | output | 1 | The engine is idle and the result is valid |
| result_o | output | WIDTH | Current content of the second register |

## Verification
The bench steps a behavioural model on every clock and compares all three outputs with it. It also checks each finished run against a remainder-based GCD.

It aims at several corner cases:
- A zero second operand. A design that only subtracts would take away zero forever and never finish.
- A zero first operand. A design that got this wrong would report busy instead of finishing at once with the other operand.
- Equal operands, which must end after one subtraction.
- A start pulse in the middle of a run. If it were accepted, the run would be corrupted and produce the wrong divisor.
- Operands near the top of the 32-bit range. These expose a subtractor or comparator that is too narrow.

// File: rtl/gcd_pkg.sv
package gcd_pkg;
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_SUB  = 2'd2,
        ACT_SWAP = 2'd3
    } gcd_act_e;
endpackage

// File: rtl/gcd_step_sel.sv
module gcd_step_sel
    import gcd_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    input  logic             start_i,
    output gcd_act_e         act_o
);
    logic x_zero;
    logic y_zero;
    logic x_ge_y;

    assign x_zero = (x_i == '0);
    assign y_zero = (y_i == '0);
    assign x_ge_y = (x_i >= y_i);

    // Priority: idle load, idle hold, zero divisor swap, subtract, swap.
    always_comb begin
        if (x_zero) begin
            act_o = start_i ? ACT_LOAD : ACT_HOLD;
        end else if (y_zero) begin
            act_o = ACT_SWAP;
        end else if (x_ge_y) begin
            act_o = ACT_SUB;
        end else begin
            act_o = ACT_SWAP;
        end
    end
endmodule

// File: rtl/gcd_flags.sv
module gcd_flags #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] result_o
);
    assign busy_o   = |x_i;
    assign done_o   = ~busy_o;
    assign result_o = y_i;
endmodule

// File: rtl/gcd_sub_engine.sv
module gcd_sub_engine
    import gcd_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] result_o
);
    typedef struct packed {
        logic [WIDTH-1:0] x;
        logic [WIDTH-1:0] y;
    } gcd_regs_t;

    gcd_regs_t st_q;
    gcd_regs_t st_d;
    gcd_act_e  act;
    logic [WIDTH-1:0] diff;

    gcd_step_sel #(.WIDTH(WIDTH)) u_sel (
        .x_i     (st_q.x),
        .y_i     (st_q.y),
        .start_i (start_i),
        .act_o   (act)
    );

    gcd_flags #(.WIDTH(WIDTH)) u_flags (
        .x_i      (st_q.x),
        .y_i      (st_q.y),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .result_o (result_o)
    );

    assign diff = st_q.x - st_q.y;

    always_comb begin
        st_d = st_q;
        unique case (act)
            ACT_LOAD: begin
                st_d.x = opa_i;
                st_d.y = opb_i;
            end
            ACT_SUB: begin
                st_d.x = diff;
            end
            ACT_SWAP: begin
                st_d.x = st_q.y;
                st_d.y = st_q.x;
            end
            default: begin
                st_d = st_q;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/gcd_sub_engine_chk.sv
module gcd_sub_engine_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [WIDTH-1:0] opa_i,
    input logic [WIDTH-1:0] opb_i,
    input logic             busy_o,
    input logic             done_o,
    input logic [WIDTH-1:0] result_o,
    input logic [WIDTH-1:0] x_q,
    input logic [WIDTH-1:0] y_q
);
    // R2
    load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (x_q == '0 && start_i) |=> (x_q == $past(opa_i) && y_q == $past(opb_i)));

    // R3
    subtract_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (x_q != '0 && y_q != '0 && x_q >= y_q) |=>
        (x_q == $past(x_q) - $past(y_q) && y_q == $past(y_q)));

    // R4
    exchange_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (x_q != '0 && x_q < y_q) |=> (x_q == $past(y_q) && y_q == $past(x_q)));

    // R5
    zero_divisor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (x_q != '0 && y_q == '0) |=> (done_o && result_o == $past(x_q)));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(result_o)));

    // R7
    flag_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o != done_o) && (busy_o == (x_q != '0)) && (result_o == y_q));

    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && x_q >= y_q && y_q != '0) |=> (y_q == $past(y_q)));
endmodule

bind gcd_sub_engine gcd_sub_engine_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .opa_i    (opa_i),
    .opb_i    (opb_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .result_o (result_o),
    .x_q      (st_q.x),
    .y_q      (st_q.y)
);

// File: tb/gcd_sub_engine_test.sv
module gcd_sub_engine_test;
    localparam int W = 32;
    localparam int WATCHDOG = 150000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [W-1:0] opa_i = '0;
    logic [W-1:0] opb_i = '0;
    logic         busy_o;
    logic         done_o;
    logic [W-1:0] result_o;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    logic [W-1:0] mx = '0;
    logic [W-1:0] my = '0;

    always #4 clk = ~clk;

    gcd_sub_engine #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .opa_i(opa_i), .opb_i(opb_i),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    function automatic logic [W-1:0] ref_gcd(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] p = a;
        logic [W-1:0] q = b;
        logic [W-1:0] t;
        while (q != 0) begin
            t = p % q;
            p = q;
            q = t;
        end
        return p;
    endfunction

    // Behavioural reference: one Euclid step per clock.
    always @(posedge clk) begin
        if (!rst_n) begin
            mx <= 0;
            my <= 0;
        end else if (mx == 0) begin
            if (start_i) begin
                mx <= opa_i;
                my <= opb_i;
            end
        end else if (my == 0 || mx < my) begin
            mx <= my;
            my <= mx;
        end else begin
            mx <= mx - my;
        end
    end

    // Compare on every clock, away from the active edge.
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            chk(busy_o == (mx != 0), "R7 busy", W'(busy_o), W'(mx != 0));
            chk(done_o == (mx == 0), "R7 done", W'(done_o), W'(mx == 0));
            chk(result_o == my, "R3 R4 result", result_o, my);
        end
        if (cycles > WATCHDOG) begin
            chk(1'b0, "watchdog", W'(cycles), W'(WATCHDOG));
            summary();
        end
    end

    task automatic pulse_start(input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        start_i = 1'b1;
        opa_i = a;
        opb_i = b;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done_o && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic run(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] g;
        g = ref_gcd(a, b);
        pulse_start(a, b);
        wait_done();
        chk(done_o && result_o == g, "R9 gcd", result_o, g);
    endtask

    initial begin
        logic [W-1:0] lf;
        logic [W-1:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy_o, "R1 busy", W'(busy_o), 0);
        chk(done_o, "R1 done", W'(done_o), 1);
        chk(result_o == 0, "R1 result", result_o, 0);
        rst_n = 1'b1;

        // R2: load while idle, visible next cycle
        pulse_start(15, 6);
        chk(result_o == 6, "R2 load y", result_o, 6);
        chk(busy_o, "R2 busy", W'(busy_o), 1);
        wait_done();
        chk(result_o == 3, "R9 15,6", result_o, 3);

        // R6: idle hold
        held = result_o;
        repeat (5) @(negedge clk);
        chk(done_o && result_o == held, "R6 hold", result_o, held);

        // R5: zero second operand
        pulse_start(9, 0);
        chk(busy_o, "R5 busy", W'(busy_o), 1);
        @(negedge clk);
        chk(done_o && result_o == 9, "R5 swap finish", result_o, 9);

        // zero first operand: done at once
        pulse_start(0, 21);
        chk(done_o && result_o == 21, "R2 zero a", result_o, 21);

        run(0, 0);
        run(77, 77);
        run(6, 15);
        run(32'hFFFF_0000, 32'h7FFF_8000);
        run(32'hFFFF_FFFF, 32'hFFFF_FFFF);

        // R8: start while busy ignored
        pulse_start(30, 12);
        @(negedge clk);
        start_i = 1'b1;
        opa_i = 7;
        opb_i = 5;
        @(negedge clk);
        start_i = 1'b0;
        wait_done();
        chk(result_o == 6, "R8 ignored start", result_o, 6);

        lf = 32'hACE1_2345;
        for (int i = 0; i < 40; i++) begin
            logic [W-1:0] a;
            logic [W-1:0] b;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            a = W'(lf[11:0] % 700);
            b = W'(lf[27:16] % 700);
            run(a, b);
        end

        repeat (2) @(negedge clk);
        summary();
    end
endmodule